// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called the A side and the B side. Each direction of travel has its own storage register. The A-to-B register samples the A-side input on the rising edge of its own capture clock. The B-to-A register samples the B-side input on the rising edge of a second, unrelated capture clock. The two registers can be loaded together or one at a time.

For each direction, a source select chooses what the far bus carries. It is either the live input from the other side, passed straight through, or the word held in that direction's register. An active-low enable and a direction input then decide which side, if any, is driven. When the enable is high the block is isolated: no side is driven, but both registers keep capturing.

Bidirectional pins are split into an input vector, an output vector and a per-bit output-enable vector for each side. This keeps the block synthesizable and the pads outside it. The output vectors always carry the selected source, and the output enables say whether that value is actually placed on the bus.

Top module: `bus_bridge_xcvr`

## Requirements
- R1: While `rst` is high at a rising capture edge, that direction's register is cleared to zero. After reset, with stored source selected, `b_out` and `a_out` read 0.
- R2: On each rising edge of `ab_cap_clk` with `rst` low, the A-to-B register takes the value on `a_in`. Between edges it holds its value.
- R3: On each rising edge of `ba_cap_clk` with `rst` low, the B-to-A register takes the value on `b_in`. Between edges it holds its value.
- R4: When `drive_en_n` is 1 (isolated), every bit of `a_oe` and of `b_oe` is 0, whatever `dir_b` and the selects are.
- R5: When `drive_en_n` is 0 and `dir_b` is 1, every bit of `b_oe` is 1 and every bit of `a_oe` is 0.
- R6: When `drive_en_n` is 0 and `dir_b` is 0, every bit of `a_oe` is 1 and every bit of `b_oe` is 0.
- R7: `src_ab` = 0 puts the live `a_in` on `b_out`, with no clock involved. `src_ab` = 1 puts the A-to-B register on `b_out`.
- R8: `src_ba` = 0 puts the live `b_in` on `a_out`. `src_ba` = 1 puts the B-to-A register on `a_out`.
- R9: Both registers still load from their inputs while `drive_en_n` is 1.
- R10: A stored word does not change while the live input on its side changes without a capture edge. It also does not change on an edge of the other direction's clock.
- R11: No bit of `a_oe` is ever high at the same time as any bit of `b_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ab_cap_clk | input | 1 | Rising-edge capture clock of the A-to-B register |
| ba_cap_clk | input | 1 | Rising-edge capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, applied on each capture clock |
| drive_en_n | input | 1 | Active-low output enable; 1 isolates both sides |
| dir_b | input | 1 | 1 drives the B side, 0 drives the A side |
| src_ab | input | 1 | B-side source: 0 live A input, 1 stored A-to-B word |
| src_ba | input | 1 | A-side source: 0 live B input, 1 stored B-to-A word |
| a_in | input | WIDTH | Value seen on the A-side pins |
| b_in | input | WIDTH | Value seen on the B-side pins |
| a_out | output | WIDTH | Value offered to the A-side pins |
| a_oe | output | WIDTH | Per-bit drive enable of the A-side pins |
| b_out | output | WIDTH | Value offered to the B-side pins |
| b_oe | output | WIDTH | Per-bit drive enable of the B-side pins |

## Verification
The capture assertions assume that `a_in` and `b_in` are steady at each rising edge of the matching capture clock. They also assume that `rst` changes only while the capture clocks are low. The bench therefore sets up data, then raises and lowers the capture clocks inside a single task. The combinational checks on the enables and on the live path assume the controls carry known values. The bench drives every control from the first instant and sweeps all sixteen combinations of enable, direction and both selects.

// File: rtl/bbx_pkg.sv
`timescale 1ns/1ps
package bbx_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef enum logic [1:0] {
        DRV_NONE = 2'b00,
        DRV_TO_A = 2'b01,
        DRV_TO_B = 2'b10
    } drive_e;

    typedef struct packed {
        logic a_side;
        logic b_side;
    } side_en_t;

    function automatic drive_e decode_drive(input logic en_n, input logic dir_b);
        if (en_n)
            return DRV_NONE;
        return dir_b ? DRV_TO_B : DRV_TO_A;
    endfunction

    function automatic side_en_t drive_to_sides(input drive_e d);
        side_en_t s;
        s.a_side = (d == DRV_TO_A);
        s.b_side = (d == DRV_TO_B);
        return s;
    endfunction

endpackage

// File: rtl/bbx_store_reg.sv
`timescale 1ns/1ps
module bbx_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/bbx_src_mux.sv
`timescale 1ns/1ps
module bbx_src_mux
    import bbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  src_sel_e         sel,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (sel)
            SRC_STORED: y = stored;
            default:    y = live;
        endcase
    end
endmodule

// File: rtl/bbx_drive_ctl.sv
`timescale 1ns/1ps
module bbx_drive_ctl
    import bbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             en_n,
    input  logic             dir_b,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_oe
);
    drive_e   mode;
    side_en_t sides;

    always_comb begin
        mode  = decode_drive(en_n, dir_b);
        sides = drive_to_sides(mode);
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit_oe
        assign a_oe[i] = sides.a_side;
        assign b_oe[i] = sides.b_side;
    end
endmodule

// File: rtl/bus_bridge_xcvr.sv
`timescale 1ns/1ps
module bus_bridge_xcvr
    import bbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             ab_cap_clk,
    input  logic             ba_cap_clk,
    input  logic             rst,
    input  logic             drive_en_n,
    input  logic             dir_b,
    input  logic             src_ab,
    input  logic             src_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);
    logic [WIDTH-1:0] held_ab;
    logic [WIDTH-1:0] held_ba;

    bbx_store_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk (ab_cap_clk),
        .rst (rst),
        .d   (a_in),
        .q   (held_ab)
    );

    bbx_store_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk (ba_cap_clk),
        .rst (rst),
        .d   (b_in),
        .q   (held_ba)
    );

    bbx_src_mux #(.WIDTH(WIDTH)) u_mux_to_b (
        .sel    (src_sel_e'(src_ab)),
        .live   (a_in),
        .stored (held_ab),
        .y      (b_out)
    );

    bbx_src_mux #(.WIDTH(WIDTH)) u_mux_to_a (
        .sel    (src_sel_e'(src_ba)),
        .live   (b_in),
        .stored (held_ba),
        .y      (a_out)
    );

    bbx_drive_ctl #(.WIDTH(WIDTH)) u_drive (
        .en_n  (drive_en_n),
        .dir_b (dir_b),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );
endmodule

// File: rtl/bbx_checker.sv
`timescale 1ns/1ps
module bbx_checker #(
    parameter int WIDTH = 8
) (
    input logic             ab_cap_clk,
    input logic             ba_cap_clk,
    input logic             rst,
    input logic             drive_en_n,
    input logic             dir_b,
    input logic             src_ab,
    input logic             src_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] a_oe,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] b_oe
);
    // R2: with stored source selected, B side shows the A word from the previous capture edge
    assert_capture_ab_R2: assert property (@(posedge ab_cap_clk) disable iff (rst)
        (src_ab && !$past(rst)) |-> (b_out == $past(a_in)));

    // R3: same for the B-to-A register seen on the A side
    assert_capture_ba_R3: assert property (@(posedge ba_cap_clk) disable iff (rst)
        (src_ba && !$past(rst)) |-> (a_out == $past(b_in)));

    // R1: a capture edge under reset leaves zero in the register
    assert_reset_ab_R1: assert property (@(posedge ab_cap_clk)
        ($past(rst) === 1'b1 && src_ab) |-> (b_out == '0));

    always_comb begin
        if (!$isunknown({drive_en_n, dir_b})) begin
            // R4: isolation drives nothing
            if (drive_en_n)
                assert_isolated_R4: assert (a_oe == '0 && b_oe == '0);
            // R11: never both sides driven
            assert_no_contention_R11: assert (!((|a_oe) && (|b_oe)));
            // R5 / R6: exactly the chosen side is fully driven
            if (!drive_en_n)
                assert_one_side_R5: assert ((dir_b ? b_oe : a_oe) == '1);
        end
        if (src_ab === 1'b0 && !$isunknown(a_in))
            assert_live_ab_R7: assert (b_out == a_in);
        if (src_ba === 1'b0 && !$isunknown(b_in))
            assert_live_ba_R8: assert (a_out == b_in);
    end
endmodule

bind bus_bridge_xcvr bbx_checker #(.WIDTH(WIDTH)) u_chk (
    .ab_cap_clk (ab_cap_clk),
    .ba_cap_clk (ba_cap_clk),
    .rst        (rst),
    .drive_en_n (drive_en_n),
    .dir_b      (dir_b),
    .src_ab     (src_ab),
    .src_ba     (src_ba),
    .a_in       (a_in),
    .b_in       (b_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_out      (b_out),
    .b_oe       (b_oe)
);

// File: tb/bus_bridge_xcvr_test.sv
`timescale 1ns/1ps
module bus_bridge_xcvr_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         ab_cap_clk = 1'b0;
    logic         ba_cap_clk = 1'b0;
    logic         rst = 1'b1;
    logic         drive_en_n = 1'b1;
    logic         dir_b = 1'b0;
    logic         src_ab = 1'b0;
    logic         src_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    bus_bridge_xcvr #(.WIDTH(W)) uut (
        .ab_cap_clk (ab_cap_clk),
        .ba_cap_clk (ba_cap_clk),
        .rst        (rst),
        .drive_en_n (drive_en_n),
        .dir_b      (dir_b),
        .src_ab     (src_ab),
        .src_ba     (src_ba),
        .a_in       (a_in),
        .b_in       (b_in),
        .a_out      (a_out),
        .a_oe       (a_oe),
        .b_out      (b_out),
        .b_oe       (b_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit do_ab, input bit do_ba);
        #2;
        if (do_ab) ab_cap_clk = 1'b1;
        if (do_ba) ba_cap_clk = 1'b1;
        #3;
        ab_cap_clk = 1'b0;
        ba_cap_clk = 1'b0;
        #2;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] sa, sb, pa, pb, exp_b, exp_a;

        // R1: reset clears both registers
        a_in = 8'h5A; b_in = 8'hC3;
        pulse(1, 1);
        rst = 1'b0;
        src_ab = 1'b1; src_ba = 1'b1;
        #1;
        check("R1 b_out after reset", b_out, '0);
        check("R1 a_out after reset", a_out, '0);
        check("R4 oe after reset a", a_oe, '0);
        check("R4 oe after reset b", b_oe, '0);

        // R2/R3/R9: load patterns, some in isolation, some together, some alone
        sa = '0; sb = '0;
        for (int i = 0; i < 16; i++) begin
            pa = W'((i * 37 + 5) & 255);
            pb = W'(((i * 91 + 3) & 255) ^ 8'hA5);
            drive_en_n = i[0];
            dir_b = i[1];
            a_in = pa; b_in = pb;
            pulse(i[2] | ~i[3], i[3] | ~i[2]);
            if (i[2] | ~i[3]) sa = pa;
            if (i[3] | ~i[2]) sb = pb;
            a_in = ~pa; b_in = ~pb;
            #1;
            check(drive_en_n ? "R9 isolated load ab" : "R2 load ab", b_out, sa);
            check(drive_en_n ? "R9 isolated load ba" : "R3 load ba", a_out, sb);
        end

        // R10: live input changes without edges; other clock's edge only
        for (int i = 0; i < 16; i++) begin
            a_in = W'(i * 17);
            b_in = W'(255 - i * 13);
            #1;
            check("R10 hold ab", b_out, sa);
            check("R10 hold ba", a_out, sb);
        end
        a_in = 8'h11; b_in = 8'h22;
        pulse(0, 1);
        sb = 8'h22;
        a_in = 8'h33; #1;
        check("R10 ab untouched by ba clock", b_out, sa);
        check("R3 ba loaded alone", a_out, sb);
        b_in = 8'h44;
        pulse(1, 0);
        sa = 8'h33;
        b_in = 8'h55; #1;
        check("R10 ba untouched by ab clock", a_out, sb);
        check("R2 ab loaded alone", b_out, sa);

        // R4-R8, R11: all 16 control combinations, several live patterns
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 16; c++) begin
                drive_en_n = c[3];
                dir_b = c[2];
                src_ab = c[1];
                src_ba = c[0];
                a_in = W'(c * 29 + p * 71 + 1);
                b_in = W'(c * 53 + p * 19 + 7);
                #1;
                exp_b = src_ab ? sa : a_in;
                exp_a = src_ba ? sb : b_in;
                check(src_ab ? "R7 stored to b" : "R7 live to b", b_out, exp_b);
                check(src_ba ? "R8 stored to a" : "R8 live to a", a_out, exp_a);
                if (drive_en_n) begin
                    check("R4 a_oe isolated", a_oe, '0);
                    check("R4 b_oe isolated", b_oe, '0);
                end else if (dir_b) begin
                    check("R5 b_oe", b_oe, '1);
                    check("R5 a_oe", a_oe, '0);
                end else begin
                    check("R6 a_oe", a_oe, '1);
                    check("R6 b_oe", b_oe, '0);
                end
                check("R11 no contention", W'((|a_oe) & (|b_oe)), '0);
            end
        end

        // R1: reset again after data is held
        src_ab = 1'b1; src_ba = 1'b1;
        rst = 1'b1;
        pulse(1, 1);
        rst = 1'b0;
        #1;
        check("R1 second reset ab", b_out, '0);
        check("R1 second reset ba", a_out, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule